// File: doc/BRIEF.md
# Debug Execution Controller

This block sits between a debug command port and a small 8-bit microcontroller core and decides when the core may fetch and execute instructions. A debugger issues one command at a time: run freely, halt, reset the core, execute one instruction, skip one instruction, step over a subroutine call, or step out of the current subroutine. The block drives a fetch enable and a skip request to the core. It also observes each instruction slot the core completes, with flags that mark calls and returns, and the core's stack pointer.

Step-over and step-out run in hardware. When the command is issued, the block loads the core's stack pointer as both a live call depth and a captured depth. It then tracks the live depth from the call and return events and stops when the live depth reaches the target for that command. While halted, only instruction fetch stops; peripherals keep running. Once the block has halted, it latches the address of the instruction that will execute next.

A breakpoint hit input is honoured in the free-running modes: run, step-over and step-out. It is ignored in the single-slot modes, so that execution can leave a breakpoint address by stepping. Start commands are accepted only while halted. While running, only halt and reset have any effect.

Top module: `dbg_exec_ctrl`

## Requirements
- R1: After rst_n is released, halted is 1, halt_pc is 0, and core_fetch_en and core_rst are 0.
- R2: While halted, core_fetch_en stays 0 until a start command arrives; a halt command, a breakpoint hit or the unused code 7 has no effect while halted.
- R3: In run mode, fetch stays enabled until a halt command or a breakpoint hit. core_fetch_en drops in the same cycle as that event, so the instruction at the current address does not execute, and halt_pc later equals that address.
- R4: Step-into (code 3) enables exactly one instruction slot and then halts; a breakpoint hit is ignored during it.
- R5: Skip (code 4) enables exactly one slot with core_skip high in that slot, so the core only advances its program counter; the block then halts.
- R6: Step-over (code 5) captures the depth; if the first instruction is a call, it runs until the live depth is back at or below the captured depth, otherwise it halts after one slot.
- R7: Step-out (code 6) runs until the live depth drops below the captured depth; with a captured depth of zero it halts after one slot.
- R8: Reset (code 2), in any state, stops fetch in the same cycle, raises core_rst for exactly the next cycle, leaves the block halted with halt_pc 0, and cancels any step in progress.
- R9: halted rises in the cycle after the last enabled slot, and from the following cycle halt_pc holds the core's current instruction address.
- R10: Command codes on cmd_code, taken when cmd_valid is 1: 0 run, 1 halt, 2 reset, 3 step-into, 4 skip, 5 step-over, 6 step-out; 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 3 | Command code (see R10) |
| bp_hit | input | 1 | Breakpoint condition at the current instruction |
| core_retire | input | 1 | Core completes the current instruction slot |
| core_call | input | 1 | The completing instruction is a call |
| core_ret | input | 1 | The completing instruction is a return |
| core_sp | input | DEPTH_W | Core stack pointer (call depth) |
| core_pc | input | PC_W | Address of the instruction in the current slot |
| core_fetch_en | output | 1 | Core may fetch and execute in this cycle |
| core_skip | output | 1 | Current slot advances the PC with no side effects |
| core_rst | output | 1 | One-cycle reset to the core |
| halted | output | 1 | Block is in the halted state |
| halt_pc | output | PC_W | Address at which the core stopped |

## Verification
core_fetch_en is combinational: a halt, reset or breakpoint input lowers it within the same cycle. The bench therefore drives inputs at the falling edge and samples one time step later. A slot counts as executed only when core_fetch_en is sampled high at the falling edge, and the bench keeps counting until halted is sampled at 1, which happens one edge after the last slot. halt_pc is captured from the core one edge after that, so it is compared at the following falling edge. core_rst is checked one edge after the reset command, and the cancelled step is checked over the six falling edges that follow it.

// File: rtl/dbg_exec_pkg.sv
// Package: shared command codes, controller states and decoded-command type.
// Assumes a 3-bit command code; code 7 is reserved and decodes to nothing.
package dbg_exec_pkg;

    typedef enum logic [2:0] {
        CMD_RUN   = 3'd0,
        CMD_HALT  = 3'd1,
        CMD_RESET = 3'd2,
        CMD_STEP  = 3'd3,
        CMD_SKIP  = 3'd4,
        CMD_OVER  = 3'd5,
        CMD_OUT   = 3'd6
    } dbg_cmd_e;

    typedef enum logic [2:0] {
        ST_HALTED,
        ST_RUN,
        ST_STEP,
        ST_SKIP,
        ST_OVER,
        ST_OUT
    } dbg_state_e;

    typedef struct packed {
        logic run;
        logic halt;
        logic rst;
        logic step;
        logic skip;
        logic over;
        logic out;
    } dbg_dec_t;

endpackage

// File: rtl/dbg_cmd_decode.sv
// Module: turns a strobed command code into one-hot request flags.
// Assumes cmd_valid lasts one cycle per command; unknown codes yield no flag.
module dbg_cmd_decode
    import dbg_exec_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    output dbg_dec_t   dec
);

    // Decode the code into at most one active request flag.
    always_comb begin
        dec = '0;
        if (cmd_valid) begin
            case (cmd_code)
                CMD_RUN:   dec.run  = 1'b1;
                CMD_HALT:  dec.halt = 1'b1;
                CMD_RESET: dec.rst  = 1'b1;
                CMD_STEP:  dec.step = 1'b1;
                CMD_SKIP:  dec.skip = 1'b1;
                CMD_OVER:  dec.over = 1'b1;
                CMD_OUT:   dec.out  = 1'b1;
                default:   dec      = '0;
            endcase
        end
    end

endmodule

// File: rtl/dbg_depth_track.sv
// Module: live call-depth counter plus the depth captured at command issue.
// Assumes call/return flags are only meaningful in slots that execute (slot=1)
// and that the core never returns with an empty stack.
module dbg_depth_track #(
    parameter int DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DEPTH_W-1:0] sp_in,
    input  logic               slot,
    input  logic               call_evt,
    input  logic               ret_evt,
    output logic               over_reached,
    output logic               out_reached
);

    logic [DEPTH_W-1:0] depth_q;
    logic [DEPTH_W-1:0] cap_q;
    logic [DEPTH_W-1:0] depth_nxt;

    // Depth after the slot currently completing.
    always_comb begin
        depth_nxt = depth_q + DEPTH_W'(call_evt) - DEPTH_W'(ret_evt);
    end

    // Targets: step-over back at/below capture, step-out strictly below it.
    always_comb begin
        over_reached = (depth_nxt <= cap_q);
        out_reached  = (cap_q == '0) || (depth_nxt < cap_q);
    end

    // Capture on command issue, follow call/return events afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
            cap_q   <= '0;
        end else if (load) begin
            depth_q <= sp_in;
            cap_q   <= sp_in;
        end else if (slot) begin
            depth_q <= depth_nxt;
        end
    end

    AST_DEPTH_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && ret_evt && !call_evt) |-> (depth_q != '0)) else $error("depth underflow"); // R7

endmodule

// File: rtl/dbg_exec_fsm.sv
// Module: halt/run state machine. Drives fetch enable, skip request and the
// one-cycle core reset. Assumes decoded commands from dbg_cmd_decode and
// depth targets from dbg_depth_track. Halt, reset and (in free-running modes)
// a breakpoint lower fetch enable in the same cycle.
module dbg_exec_fsm
    import dbg_exec_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  dbg_dec_t dec,
    input  logic     bp_hit,
    input  logic     retire,
    input  logic     over_reached,
    input  logic     out_reached,
    output logic     fetch_en,
    output logic     skip_req,
    output logic     slot_done,
    output logic     load_depth,
    output logic     core_rst,
    output logic     halted
);

    dbg_state_e state_q;
    dbg_state_e state_d;
    logic       rst_q;
    logic       running;
    logic       free_run;
    logic       stop_now;
    logic       target_met;
    logic       start_cmd;

    // Classify the current state and the stop requests of this cycle.
    always_comb begin
        running  = (state_q != ST_HALTED);
        free_run = (state_q == ST_RUN) || (state_q == ST_OVER) || (state_q == ST_OUT);
        stop_now = dec.rst || dec.halt || (free_run && bp_hit);
        fetch_en = running && !stop_now;
        skip_req = (state_q == ST_SKIP) && fetch_en;
        slot_done = fetch_en && retire;
        start_cmd = dec.run || dec.step || dec.skip || dec.over || dec.out;
        load_depth = !running && start_cmd && !dec.rst;
    end

    // Per-mode completion test for the slot now finishing.
    always_comb begin
        case (state_q)
            ST_STEP, ST_SKIP: target_met = 1'b1;
            ST_OVER:          target_met = over_reached;
            ST_OUT:           target_met = out_reached;
            default:          target_met = 1'b0;
        endcase
    end

    // Next-state selection: reset first, then start commands, then stops.
    always_comb begin
        state_d = state_q;
        if (dec.rst) begin
            state_d = ST_HALTED;
        end else if (!running) begin
            if (dec.run)       state_d = ST_RUN;
            else if (dec.step) state_d = ST_STEP;
            else if (dec.skip) state_d = ST_SKIP;
            else if (dec.over) state_d = ST_OVER;
            else if (dec.out)  state_d = ST_OUT;
        end else if (stop_now || (slot_done && target_met)) begin
            state_d = ST_HALTED;
        end
    end

    // State and one-cycle core reset registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALTED;
            rst_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rst_q   <= dec.rst;
        end
    end

    assign core_rst = rst_q;
    assign halted   = (state_q == ST_HALTED);

    AST_STEP_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_STEP) && slot_done) |=> halted) else $error("step overran"); // R4
    AST_SKIP_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SKIP) && slot_done) |=> (halted && !skip_req)) else $error("skip overran"); // R5
    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> !core_rst) else $error("core reset too long"); // R8
    AST_RST_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        dec.rst |=> (halted && core_rst)) else $error("reset did not halt"); // R8
    AST_HALT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (running && dec.halt) |=> halted) else $error("halt ignored"); // R3

endmodule

// File: rtl/dbg_exec_ctrl.sv
// Module (top): debug execution controller. Wires the command decoder,
// the depth tracker and the state machine, and latches the stop address.
// Assumes core_pc is the address of the instruction in the current slot and
// core_retire reports completion of a slot enabled in the same cycle.
module dbg_exec_ctrl
    import dbg_exec_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_code,
    input  logic               bp_hit,
    input  logic               core_retire,
    input  logic               core_call,
    input  logic               core_ret,
    input  logic [DEPTH_W-1:0] core_sp,
    input  logic [PC_W-1:0]    core_pc,
    output logic               core_fetch_en,
    output logic               core_skip,
    output logic               core_rst,
    output logic               halted,
    output logic [PC_W-1:0]    halt_pc
);

    dbg_dec_t dec;
    logic     slot_done;
    logic     load_depth;
    logic     over_reached;
    logic     out_reached;

    dbg_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .dec       (dec)
    );

    dbg_depth_track #(.DEPTH_W(DEPTH_W)) u_depth (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load_depth),
        .sp_in        (core_sp),
        .slot         (slot_done),
        .call_evt     (core_call),
        .ret_evt      (core_ret),
        .over_reached (over_reached),
        .out_reached  (out_reached)
    );

    dbg_exec_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .dec          (dec),
        .bp_hit       (bp_hit),
        .retire       (core_retire),
        .over_reached (over_reached),
        .out_reached  (out_reached),
        .fetch_en     (core_fetch_en),
        .skip_req     (core_skip),
        .slot_done    (slot_done),
        .load_depth   (load_depth),
        .core_rst     (core_rst),
        .halted       (halted)
    );

    // Stop-address register: zero on reset command, else follows the core while halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_pc <= '0;
        end else if (dec.rst) begin
            halt_pc <= '0;
        end else if (halted && !core_rst) begin
            halt_pc <= core_pc;
        end
    end

    AST_HALTED_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !core_fetch_en) else $error("fetch while halted"); // R2
    AST_RST_PC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> (halt_pc == '0)) else $error("stop address not cleared"); // R8

endmodule

// File: tb/dbg_exec_ctrl_tb_top.sv
// Bench: small core model with a fixed program, a vector table walked by one
// loop, then directed reset, halt and ignored-command tests.
module dbg_exec_ctrl_tb_top;

    localparam int PC_W    = 13;
    localparam int DEPTH_W = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_valid = 1'b0;
    logic [2:0]         cmd_code = 3'd0;
    logic               bp_hit;
    logic               core_retire;
    logic               core_call;
    logic               core_ret;
    logic [DEPTH_W-1:0] core_sp;
    logic [PC_W-1:0]    core_pc;
    logic               core_fetch_en;
    logic               core_skip;
    logic               core_rst;
    logic               halted;
    logic [PC_W-1:0]    halt_pc;

    logic               bp_en = 1'b0;
    logic [PC_W-1:0]    bp_addr = '0;
    logic [PC_W-1:0]    ret_stk [4];
    int                 errors = 0;
    int                 checks = 0;
    bit                 done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    dbg_exec_ctrl #(.PC_W(PC_W), .DEPTH_W(DEPTH_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_code      (cmd_code),
        .bp_hit        (bp_hit),
        .core_retire   (core_retire),
        .core_call     (core_call),
        .core_ret      (core_ret),
        .core_sp       (core_sp),
        .core_pc       (core_pc),
        .core_fetch_en (core_fetch_en),
        .core_skip     (core_skip),
        .core_rst      (core_rst),
        .halted        (halted),
        .halt_pc       (halt_pc)
    );

    // Program: 1,3,5 call 8; 9 calls 12; 10 and 13 return; all else no-op.
    function automatic int kind_of(input logic [PC_W-1:0] pc);
        if (pc == 1 || pc == 3 || pc == 5 || pc == 9) return 1;
        if (pc == 10 || pc == 13) return 2;
        return 0;
    endfunction

    function automatic logic [PC_W-1:0] target_of(input logic [PC_W-1:0] pc);
        return (pc == 9) ? PC_W'(12) : PC_W'(8);
    endfunction

    // Core model: one instruction per enabled cycle.
    always_comb begin
        core_retire = core_fetch_en;
        core_call   = core_fetch_en && !core_skip && (kind_of(core_pc) == 1);
        core_ret    = core_fetch_en && !core_skip && (kind_of(core_pc) == 2);
        bp_hit      = bp_en && (core_pc == bp_addr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || core_rst) begin
            core_pc <= '0;
            core_sp <= '0;
        end else if (core_fetch_en) begin
            if (core_skip || kind_of(core_pc) == 0) begin
                core_pc <= core_pc + 1'b1;
            end else if (kind_of(core_pc) == 1) begin
                ret_stk[core_sp[1:0]] <= core_pc + 1'b1;
                core_sp <= core_sp + 1'b1;
                core_pc <= target_of(core_pc);
            end else begin
                core_pc <= ret_stk[core_sp[1:0] - 2'd1];
                core_sp <= core_sp - 1'b1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue a command in one cycle; returns at the next falling edge + 1.
    task automatic issue(input logic [2:0] code);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        #1;
    endtask

    task automatic release_cmd();
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
    endtask

    // Vector: [27:25] cmd, [24] bp_en, [23:16] bp addr, [15:8] stop pc, [7:0] slots.
    localparam logic [27:0] VEC [10] = '{
        {3'd3, 1'b0, 8'd0,  8'd1,  8'd1},   // R4 step-into a no-op
        {3'd5, 1'b0, 8'd0,  8'd2,  8'd6},   // R6 step-over a nested call
        {3'd5, 1'b0, 8'd0,  8'd3,  8'd1},   // R6 step-over a no-op
        {3'd3, 1'b0, 8'd0,  8'd8,  8'd1},   // R4 step-into a call
        {3'd6, 1'b0, 8'd0,  8'd4,  8'd5},   // R7 step-out through nested call
        {3'd6, 1'b0, 8'd0,  8'd5,  8'd1},   // R7 step-out at depth zero
        {3'd4, 1'b0, 8'd0,  8'd6,  8'd1},   // R5 skip a call
        {3'd0, 1'b1, 8'd12, 8'd12, 8'd4},   // R3 run to breakpoint
        {3'd3, 1'b1, 8'd12, 8'd13, 8'd1},   // R4 step off a breakpoint
        {3'd6, 1'b0, 8'd0,  8'd10, 8'd1}    // R7 step-out by one return
    };

    initial begin : main
        int pc_hold;
        int fcnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 halted", int'(halted), 1);
        chk("R1 halt_pc", int'(halt_pc), 0);
        chk("R1 fetch_en", int'(core_fetch_en), 0);
        chk("R1 core_rst", int'(core_rst), 0);

        for (int i = 0; i < 10; i++) begin
            int slots;
            int skips;
            int guard;
            logic [27:0] v;
            v = VEC[i];
            slots = 0;
            skips = 0;
            guard = 0;
            bp_en   = v[24];
            bp_addr = PC_W'(v[23:16]);
            issue(v[27:25]);
            release_cmd();
            while (!halted && guard < 1000) begin
                if (core_fetch_en) slots++;
                if (core_skip) skips++;
                @(negedge clk);
                #1;
                guard++;
            end
            @(negedge clk);
            #1;
            // R9 stop address one cycle after halted; R10 codes drive the mode
            chk($sformatf("R9 R10 vector %0d stop pc", i), int'(halt_pc), int'(v[15:8]));
            chk($sformatf("R10 vector %0d slot count", i), slots, int'(v[7:0]));
            chk($sformatf("R5 vector %0d skip slots", i), skips, (v[27:25] == 3'd4) ? 1 : 0);
        end
        bp_en = 1'b0;

        // R8 reset command
        issue(3'd2);
        release_cmd();
        chk("R8 core_rst pulse", int'(core_rst), 1);
        chk("R8 halted after reset", int'(halted), 1);
        @(negedge clk);
        #1;
        chk("R8 core_rst one cycle", int'(core_rst), 0);
        chk("R8 halt_pc zero", int'(halt_pc), 0);

        // R3 halt command wins in the same cycle
        issue(3'd0);
        release_cmd();
        repeat (3) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = 3'd1;
        #1;
        pc_hold = int'(core_pc);
        chk("R3 fetch dropped with halt", int'(core_fetch_en), 0);
        release_cmd();
        chk("R3 halted after halt", int'(halted), 1);
        @(negedge clk);
        #1;
        chk("R3 stop pc at halt", int'(halt_pc), pc_hold);

        // R8 reset cancels a step-over in progress
        issue(3'd2);
        release_cmd();
        @(negedge clk);
        #1;
        issue(3'd3);
        release_cmd();
        @(negedge clk);
        #1;
        issue(3'd5);
        @(negedge clk);
        cmd_code = 3'd2;
        #1;
        fcnt = 0;
        for (int k = 0; k < 6; k++) begin
            if (k == 1) cmd_valid = 1'b0;
            if (core_fetch_en) fcnt++;
            @(negedge clk);
            #1;
        end
        cmd_valid = 1'b0;
        chk("R8 step-over cancelled", fcnt, 0);
        chk("R8 halted after cancel", int'(halted), 1);
        chk("R8 stop pc zero after cancel", int'(halt_pc), 0);

        // R2 R10 halt, breakpoint and code 7 ignored while halted
        bp_en   = 1'b1;
        bp_addr = core_pc;
        issue(3'd7);
        @(negedge clk);
        cmd_code = 3'd1;
        #1;
        fcnt = 0;
        for (int k = 0; k < 4; k++) begin
            if (k == 1) cmd_valid = 1'b0;
            if (core_fetch_en) fcnt++;
            @(negedge clk);
            #1;
        end
        cmd_valid = 1'b0;
        bp_en = 1'b0;
        chk("R2 no fetch while halted", fcnt, 0);
        chk("R2 still halted", int'(halted), 1);
        chk("R2 stop pc unchanged", int'(halt_pc), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule